// File: doc/BRIEF.md
# Virtual Output Queue Crossbar Scheduler

This block decides, once per timeslot, which input of an N-by-N crossbar is connected to which output. Each input has N separate queues, one per output, so a packet waiting for a busy output does not hold up packets behind it that are going elsewhere. The block does not store packets. It keeps one occupancy counter per (input, output) queue. Enqueue and dequeue strobes move these counters. From the set of non-empty queues it builds a one-to-one matching between inputs and outputs.

The matching is computed by a fixed number of request, grant and accept rounds, all unrolled into combinational logic. Each output has a round-robin grant pointer and each input has a round-robin accept pointer. The result is registered when `slot_tick` is high and is held until the next tick. The surrounding datapath dequeues from an input by pulsing `deq_vld`. The dequeue always removes from the queue that the current grant names. A dequeue that has nothing to remove is flagged on `deq_err` one cycle later.

Top module: `voq_xbar_sched`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `gnt_vld`, `voq_full` and `deq_err` are all zero, and all round-robin pointers are at index 0.
- R2: After every tick, each input holds at most one output (`gnt_out[i*W +: W]`, valid when `gnt_vld[i]`), and no two valid inputs hold the same output.
- R3: A grant from input i to output j is issued only if queue (i,j) was non-empty at the tick edge. A tick with every queue empty yields no grants.
- R4: The matching is maximal. After a tick, no queue (i,j) that was non-empty at the tick has both input i and output j left unmatched. With every queue non-empty, all N inputs are matched.
- R5: An input whose queue for an output is losing contention is still matched to a different free output for which it holds packets, in the same timeslot.
- R6: In the first round, an output grants the first requesting input at or after its grant pointer, in increasing index order with wrap-around. An input accepts the first granting output at or after its accept pointer. Both pointers move to one past the matched partner only when a grant is accepted in the first round. Two inputs that contend for one output therefore alternate on successive ticks.
- R7: Between ticks, `gnt_vld` and `gnt_out` do not change.
- R8: `enq_vld[i]` with `enq_dst[i*W +: W]` = j adds one to queue (i,j). A counter holds at DEPTH, and an enqueue into a full queue is dropped. `voq_full[i*N+j]` is high exactly when queue (i,j) holds DEPTH.
- R9: `deq_vld[i]` removes one from queue (i, current granted output) when input i is granted and that queue is non-empty. Otherwise nothing is removed, and `deq_err[i]` is high on the next cycle.
- R10: An enqueue and a valid dequeue on the same queue in the same cycle leave its count unchanged, including when the queue is full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot_tick | input | 1 | Timeslot boundary; registers a new matching |
| enq_vld | input | N | Per-input enqueue strobe |
| enq_dst | input | N*W | Per-input destination output of the enqueue |
| deq_vld | input | N | Per-input dequeue strobe against the current grant |
| gnt_vld | output | N | Input i is connected this timeslot |
| gnt_out | output | N*W | Output index connected to input i |
| voq_full | output | N*N | Queue (i,j) at depth, bit i*N+j |
| deq_err | output | N | Dequeue had nothing to remove (registered) |

## Verification
The bound checker tests the properties of the schedule itself after every tick. These are one-to-one output use, grants only to queues that were non-empty at the tick, maximality against the snapshot of non-empty queues, hold of the grant between ticks, and the error flag after a dequeue on an ungranted input. Exact round-robin order and the escape from head-of-line blocking are shown only by the bench scenarios, which predict specific grant vectors. The same holds for counter saturation, for the behaviour of simultaneous enqueue and dequeue, and for the dequeue of an empty granted queue.

// File: rtl/voq_sched_pkg.sv
package voq_sched_pkg;
  function automatic int unsigned idx_w(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/rr_pick.sv
module rr_pick #(
  parameter int N = 4,
  parameter int W = 2
) (
  input  logic [N-1:0] req,
  input  logic [W-1:0] ptr,
  output logic         found,
  output logic [W-1:0] idx
);
  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int k = 0; k < N; k++) begin
      int p;
      p = int'(ptr) + k;
      if (p >= N) p = p - N;
      if (!found && req[p]) begin
        found = 1'b1;
        idx   = W'(p);
      end
    end
  end
endmodule

// File: rtl/voq_occ_bank.sv
module voq_occ_bank #(
  parameter int N     = 4,
  parameter int DEPTH = 8,
  parameter int W     = 2,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N-1:0]        enq_vld,
  input  logic [N-1:0][W-1:0] enq_dst,
  input  logic [N-1:0]        deq_vld,
  input  logic [N-1:0]        gnt_vld,
  input  logic [N-1:0][W-1:0] gnt_out,
  output logic [N*N-1:0]      nonempty,
  output logic [N*N-1:0]      full,
  output logic [N-1:0]        deq_err
);
  logic [N-1:0][N-1:0] dec_m;

  for (genvar i = 0; i < N; i++) begin : g_in
    for (genvar j = 0; j < N; j++) begin : g_q
      logic [CW-1:0] cnt;
      logic          inc;
      logic          dec;
      assign dec = deq_vld[i] && gnt_vld[i] && (gnt_out[i] == W'(j)) && (cnt != '0);
      assign inc = enq_vld[i] && (enq_dst[i] == W'(j)) && ((cnt != CW'(DEPTH)) || dec);
      assign dec_m[i][j] = dec;
      always_ff @(posedge clk) begin
        if (rst)               cnt <= '0;
        else if (inc && !dec)  cnt <= cnt + 1'b1;
        else if (dec && !inc)  cnt <= cnt - 1'b1;
      end
      assign nonempty[i*N+j] = (cnt != '0);
      assign full[i*N+j]     = (cnt == CW'(DEPTH));
    end

    always_ff @(posedge clk) begin
      if (rst) deq_err[i] <= 1'b0;
      else     deq_err[i] <= deq_vld[i] && (dec_m[i] == '0);
    end
  end
endmodule

// File: rtl/voq_match_core.sv
module voq_match_core #(
  parameter int N     = 4,
  parameter int W     = 2,
  parameter int ITERS = 4
) (
  input  logic [N*N-1:0]      req,
  input  logic [N-1:0][W-1:0] gptr,
  input  logic [N-1:0][W-1:0] aptr,
  output logic [N-1:0]        m_vld,
  output logic [N-1:0][W-1:0] m_out,
  output logic [N-1:0][W-1:0] gptr_n,
  output logic [N-1:0][W-1:0] aptr_n
);
  logic [N-1:0]        in_free  [ITERS+1];
  logic [N-1:0]        out_free [ITERS+1];
  logic [N-1:0]        acc_f    [ITERS];
  logic [N-1:0][W-1:0] acc_i    [ITERS];

  assign in_free[0]  = '1;
  assign out_free[0] = '1;

  for (genvar t = 0; t < ITERS; t++) begin : g_it
    logic [N-1:0]        gfound;
    logic [N-1:0][W-1:0] gidx;
    logic [N-1:0]        afound;
    logic [N-1:0][W-1:0] aidx;
    logic [N-1:0]        out_taken;

    for (genvar j = 0; j < N; j++) begin : g_out
      logic [N-1:0] col;
      always_comb begin
        for (int i = 0; i < N; i++)
          col[i] = req[i*N+j] && in_free[t][i] && out_free[t][j];
      end
      rr_pick #(.N(N), .W(W)) u_gnt (
        .req(col), .ptr(gptr[j]), .found(gfound[j]), .idx(gidx[j]));
    end

    for (genvar i = 0; i < N; i++) begin : g_inp
      logic [N-1:0] row;
      always_comb begin
        for (int j = 0; j < N; j++)
          row[j] = gfound[j] && (gidx[j] == W'(i));
      end
      rr_pick #(.N(N), .W(W)) u_acc (
        .req(row), .ptr(aptr[i]), .found(afound[i]), .idx(aidx[i]));
    end

    always_comb begin
      out_taken = '0;
      for (int i = 0; i < N; i++)
        if (afound[i]) out_taken[aidx[i]] = 1'b1;
    end

    assign in_free[t+1]  = in_free[t] & ~afound;
    assign out_free[t+1] = out_free[t] & ~out_taken;
    assign acc_f[t]      = afound;
    assign acc_i[t]      = aidx;
  end

  function automatic logic [W-1:0] wrap_inc(input logic [W-1:0] x);
    return (x == W'(N - 1)) ? '0 : x + 1'b1;
  endfunction

  always_comb begin
    m_vld = '0;
    m_out = '0;
    for (int i = 0; i < N; i++)
      for (int t = 0; t < ITERS; t++)
        if (acc_f[t][i]) begin
          m_vld[i] = 1'b1;
          m_out[i] = acc_i[t][i];
        end
  end

  always_comb begin
    gptr_n = gptr;
    aptr_n = aptr;
    for (int i = 0; i < N; i++)
      if (acc_f[0][i]) begin
        aptr_n[i]             = wrap_inc(acc_i[0][i]);
        gptr_n[acc_i[0][i]]   = wrap_inc(W'(i));
      end
  end
endmodule

// File: rtl/voq_xbar_sched.sv
module voq_xbar_sched
  import voq_sched_pkg::*;
#(
  parameter int N     = 4,
  parameter int DEPTH = 8,
  parameter int ITERS = N,
  localparam int W    = idx_w(N)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             slot_tick,
  input  logic [N-1:0]     enq_vld,
  input  logic [N*W-1:0]   enq_dst,
  input  logic [N-1:0]     deq_vld,
  output logic [N-1:0]     gnt_vld,
  output logic [N*W-1:0]   gnt_out,
  output logic [N*N-1:0]   voq_full,
  output logic [N-1:0]     deq_err
);
  logic [N-1:0][W-1:0] enq_dst_p;
  logic [N-1:0][W-1:0] gnt_out_q;
  logic [N-1:0][W-1:0] gptr_q, aptr_q, gptr_n, aptr_n, m_out;
  logic [N-1:0]        gnt_vld_q, m_vld;
  logic [N*N-1:0]      req_w;

  assign enq_dst_p = enq_dst;

  voq_occ_bank #(.N(N), .DEPTH(DEPTH), .W(W)) u_occ (
    .clk(clk), .rst(rst),
    .enq_vld(enq_vld), .enq_dst(enq_dst_p),
    .deq_vld(deq_vld), .gnt_vld(gnt_vld_q), .gnt_out(gnt_out_q),
    .nonempty(req_w), .full(voq_full), .deq_err(deq_err));

  voq_match_core #(.N(N), .W(W), .ITERS(ITERS)) u_match (
    .req(req_w), .gptr(gptr_q), .aptr(aptr_q),
    .m_vld(m_vld), .m_out(m_out), .gptr_n(gptr_n), .aptr_n(aptr_n));

  always_ff @(posedge clk) begin
    if (rst) begin
      gnt_vld_q <= '0;
      gnt_out_q <= '0;
      gptr_q    <= '0;
      aptr_q    <= '0;
    end else if (slot_tick) begin
      gnt_vld_q <= m_vld;
      gnt_out_q <= m_out;
      gptr_q    <= gptr_n;
      aptr_q    <= aptr_n;
    end
  end

  assign gnt_vld = gnt_vld_q;
  assign gnt_out = gnt_out_q;
endmodule

// File: rtl/voq_xbar_sched_chk.sv
module voq_xbar_sched_chk #(
  parameter int N = 4,
  parameter int W = 2
) (
  input logic           clk,
  input logic           rst,
  input logic           slot_tick,
  input logic [N*N-1:0] req,
  input logic [N-1:0]   gnt_vld,
  input logic [N*W-1:0] gnt_out,
  input logic [N-1:0]   deq_vld,
  input logic [N-1:0]   deq_err
);
  logic [N*N-1:0] req_snap;
  logic           conflict, bad_grant, not_maximal;
  logic [N-1:0]   out_used;

  always_ff @(posedge clk) begin
    if (rst)            req_snap <= '0;
    else if (slot_tick) req_snap <= req;
  end

  always_comb begin
    conflict  = 1'b0;
    bad_grant = 1'b0;
    out_used  = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_vld[i]) begin
        if (!req_snap[i*N + int'(gnt_out[i*W +: W])]) bad_grant = 1'b1;
        out_used[gnt_out[i*W +: W]] = 1'b1;
      end
      for (int k = i + 1; k < N; k++)
        if (gnt_vld[i] && gnt_vld[k] && gnt_out[i*W +: W] == gnt_out[k*W +: W])
          conflict = 1'b1;
    end
    not_maximal = 1'b0;
    for (int i = 0; i < N; i++)
      for (int j = 0; j < N; j++)
        if (req_snap[i*N+j] && !gnt_vld[i] && !out_used[j]) not_maximal = 1'b1;
  end

  // R2
  out_conflict_chk: assert property (@(posedge clk) disable iff (rst)
    !conflict);

  // R3
  grant_nonempty_chk: assert property (@(posedge clk) disable iff (rst)
    $past(slot_tick) |-> !bad_grant);

  // R4
  maximal_match_chk: assert property (@(posedge clk) disable iff (rst)
    $past(slot_tick) |-> !not_maximal);

  // R7
  grant_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(slot_tick) |-> ($stable(gnt_vld) && $stable(gnt_out)));

  // R9
  deq_err_chk: assert property (@(posedge clk) disable iff (rst)
    ((deq_vld & ~gnt_vld) != '0) |=>
      ((deq_err & $past(deq_vld & ~gnt_vld)) == $past(deq_vld & ~gnt_vld)));
endmodule

bind voq_xbar_sched voq_xbar_sched_chk #(.N(N), .W(W)) u_chk (
  .clk(clk), .rst(rst), .slot_tick(slot_tick), .req(req_w),
  .gnt_vld(gnt_vld), .gnt_out(gnt_out), .deq_vld(deq_vld), .deq_err(deq_err));

// File: tb/voq_xbar_sched_tb_top.sv
`timescale 1ns/1ps
module voq_xbar_sched_tb_top;
  localparam int N = 4;
  localparam int DEPTH = 8;
  localparam int W = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic slot_tick = 1'b0;
  logic [N-1:0]   enq_vld = '0;
  logic [N*W-1:0] enq_dst = '0;
  logic [N-1:0]   deq_vld = '0;
  logic [N-1:0]   gnt_vld;
  logic [N*W-1:0] gnt_out;
  logic [N*N-1:0] voq_full;
  logic [N-1:0]   deq_err;

  always #2.5 clk = ~clk;

  voq_xbar_sched #(.N(N), .DEPTH(DEPTH)) dut_i (
    .clk(clk), .rst(rst), .slot_tick(slot_tick),
    .enq_vld(enq_vld), .enq_dst(enq_dst), .deq_vld(deq_vld),
    .gnt_vld(gnt_vld), .gnt_out(gnt_out), .voq_full(voq_full), .deq_err(deq_err));

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    string          tag;
    logic [N-1:0]   vld;
    logic [N*W-1:0] out;
    bit             perm;
  } exp_t;
  exp_t exp_q[$];

  bit tick_d = 0;
  always @(posedge clk) tick_d <= slot_tick;

  // monitor: pops one expected grant set per registered tick
  always @(negedge clk) begin
    if (tick_d && exp_q.size() > 0) begin
      exp_t e;
      bit ok;
      logic [N-1:0] used;
      e = exp_q.pop_front();
      ok = 1;
      checks++;
      if (e.perm) begin
        used = '0;
        for (int i = 0; i < N; i++) used[gnt_out[i*W +: W]] = 1'b1;
        if (gnt_vld != '1 || used != '1) ok = 0;
      end else begin
        if (gnt_vld != e.vld) ok = 0;
        for (int i = 0; i < N; i++)
          if (e.vld[i] && gnt_out[i*W +: W] != e.out[i*W +: W]) ok = 0;
      end
      if (!ok) begin
        errors++;
        $display("FAIL %s: gnt_vld=%b gnt_out=%h expected vld=%b out=%h perm=%0d",
                 e.tag, gnt_vld, gnt_out, e.vld, e.out, e.perm);
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [N*W-1:0] outs(int o0, int o1, int o2, int o3);
    return {W'(o3), W'(o2), W'(o1), W'(o0)};
  endfunction

  task automatic enq(int i, int j, int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      enq_vld = '0;
      enq_vld[i] = 1'b1;
      enq_dst[i*W +: W] = W'(j);
    end
    @(negedge clk);
    enq_vld = '0;
  endtask

  task automatic tick(string tag, logic [N-1:0] v, logic [N*W-1:0] o, bit perm);
    exp_t e;
    e.tag = tag; e.vld = v; e.out = o; e.perm = perm;
    exp_q.push_back(e);
    @(negedge clk);
    slot_tick = 1'b1;
    @(negedge clk);
    slot_tick = 1'b0;
  endtask

  task automatic deq(logic [N-1:0] m);
    @(negedge clk);
    deq_vld = m;
    @(negedge clk);
    deq_vld = '0;
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1 gnt_vld", 32'(gnt_vld), 0);
    chk("R1 voq_full", 32'(voq_full), 0);
    chk("R1 deq_err", 32'(deq_err), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 after release", 32'({gnt_vld, deq_err}), 0);

    // R3: empty queues produce no grants
    tick("R3 empty tick", 4'b0000, '0, 0);

    // R5: in1 loses out0 to in0 but still reaches out1
    enq(0, 0, 3);
    enq(1, 0, 3);
    enq(1, 1, 1);
    enq(2, 2, 1);
    tick("R5 hol escape", 4'b0111, outs(0, 1, 2, 0), 0);
    deq(4'b0111);
    chk("R9 valid dequeues no error", 32'(deq_err), 0);

    // R6: contention on out0 alternates between in1 and in0
    tick("R6 slot2 in1", 4'b0010, outs(0, 0, 0, 0), 0);
    deq(4'b0010);
    tick("R6 slot3 in0", 4'b0001, outs(0, 0, 0, 0), 0);
    deq(4'b0001);
    tick("R6 slot4 in1", 4'b0010, outs(0, 0, 0, 0), 0);

    // R7: grant held without tick
    repeat (5) @(negedge clk);
    chk("R7 hold vld", 32'(gnt_vld), 32'b0010);
    chk("R7 hold out", 32'(gnt_out[1*W +: W]), 0);

    // R9: dequeue on ungranted input, then drain and dequeue empty
    deq(4'b1000);
    chk("R9 ungranted dequeue", 32'(deq_err), 32'b1000);
    deq(4'b0010);
    chk("R9 dequeue count 2->1", 32'(deq_err), 0);
    deq(4'b0010);
    chk("R9 dequeue count 1->0", 32'(deq_err), 0);
    deq(4'b0010);
    chk("R9 empty granted dequeue", 32'(deq_err), 32'b0010);
    tick("R9 in1 queue drained", 4'b0001, outs(0, 0, 0, 0), 0);
    deq(4'b0001);

    // R8: saturation and full flag at bit i*N+j
    enq(3, 1, DEPTH + 2);
    chk("R8 full flag", 32'(voq_full), 32'(1 << 13));
    tick("R8 grant 3->1", 4'b1000, outs(0, 0, 0, 1), 0);
    deq(4'b1000);
    chk("R8 not full after dequeue", 32'(voq_full), 0);
    enq(3, 1, 1);
    chk("R8 saturated at depth", 32'(voq_full), 32'(1 << 13));

    // R10: simultaneous enqueue and dequeue on a full queue
    @(negedge clk);
    enq_vld = 4'b1000;
    enq_dst[3*W +: W] = W'(1);
    deq_vld = 4'b1000;
    @(negedge clk);
    enq_vld = '0;
    deq_vld = '0;
    chk("R10 full kept", 32'(voq_full), 32'(1 << 13));
    chk("R10 no error", 32'(deq_err), 0);
    deq(4'b1000);
    chk("R10 count was depth", 32'(voq_full), 0);

    // R4 / R2: every queue non-empty gives a perfect matching
    for (int j = 0; j < N; j++) begin
      @(negedge clk);
      enq_vld = '1;
      for (int i = 0; i < N; i++) enq_dst[i*W +: W] = W'(j);
    end
    @(negedge clk);
    enq_vld = '0;
    tick("R4 R2 full matrix", '1, '0, 1);
    tick("R4 R2 full matrix again", '1, '0, 1);

    repeat (3) @(negedge clk);
    chk("scoreboard drained", 32'(exp_q.size()), 0);
    summary();
  end
endmodule